// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block behaves like a small serial EEPROM that holds an array of 16-bit words. A host drives a select line, a serial clock and a serial data input; the block answers on a serial data output. While select is high, the host sends a start bit of 1, a 2-bit operation code and a word address, most significant bit first. Commands that store data are followed by 16 data bits. The block then reads, writes or erases one word, or erases or fills the whole array. It also sets or clears a latch that gates every programming command.

The block runs on a fast system clock. It samples the serial clock and acts on each rising serial clock edge. The address width is a parameter, normally 6 or 8 bits. Storage is a plain register array that resets to the erased value. Real programming time and busy signalling are not modelled: each command takes effect on the edge that carries its last bit.

Top module: `sereep_model`

## Requirements
- R1: After reset, `sdo` is 0, the write-enable latch is clear, and every word reads 16'hFFFF.
- R2: While `sel` is high and the block waits for a command, 0 bits on `sdi` are skipped. The first 1 bit is the start bit, and the next two bits form the operation code.
- R3: Operation code 2'b10 reads a word. On the rising serial clock edge that carries the last address bit, `sdo` becomes 0. Each of the next 16 rising edges presents one data bit, from bit 15 down to bit 0. The edge after that returns `sdo` to 0.
- R4: Operation code 2'b01 takes 16 data bits, most significant first, after the address. It stores them in the addressed word on the edge of the last data bit.
- R5: Operation code 2'b11 sets the addressed word to 16'hFFFF.
- R6: With operation code 2'b00, the two top address bits choose the command. 2'b11 sets the write-enable latch and 2'b00 clears it. The lower address bits have no effect.
- R7: With operation code 2'b00 and top address bits 2'b10, every word becomes 16'hFFFF.
- R8: With operation code 2'b00 and top address bits 2'b01, the 16 data bits that follow are written to every word.
- R9: Write, erase, erase-all and write-all change no word while the write-enable latch is clear.
- R10: Dropping `sel` before a command's last bit aborts the command with no change to storage. The block then waits for a new start bit.
- R11: `sdo` is 0 whenever the block is not presenting a read data bit, and in particular whenever `sel` is low.
- R12: The address is `AW` bits wide and is sent most significant bit first. Every one of the 2**AW words can be addressed on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Chip select; high while a command is being sent |
| sclk | input | 1 | Serial clock; the block acts on each rising edge |
| sdi | input | 1 | Serial command, address and data input |
| sdo | output | 1 | Serial read data output |

## Verification
The bench fills every word of a 6-bit-address array with its own pattern and reads each word back. An address that is shifted in the wrong order, or a data bit dropped or repeated, shows up as a wrong word. Every read also checks the dummy leading 0 and the 0 that follows bit 0; a design without the dummy bit would return the word shifted by one place.

The bench checks that programming commands are refused before the latch is set, after it is cleared, and again after a mid-test reset; a latch that resets set, or is ignored, lets writes through. It drops select in the middle of a write to catch a design that stores partial data, and sends leading zeros to catch one that takes any bit as the start bit. It also uses odd values in the ignored address bits of the extended commands, so that a design decoding the full address would misread them.

// File: rtl/sereep_model.sv
module sereep_model #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(DW + 1) + 1;

  typedef enum logic [2:0] {IDLE, OPC, ADR, DAT, RDO, FIN} phase_t;

  phase_t        phase;
  logic          sclk_q, wen, sdo_q;
  logic [1:0]    op;
  logic [AW-1:0] adr;
  logic [DW-1:0] dat, rsh;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];

  wire          rise    = sclk & ~sclk_q;
  wire [AW-1:0] adr_nx  = {adr[AW-2:0], sdi};
  wire [DW-1:0] dat_nx  = {dat[DW-2:0], sdi};
  wire [1:0]    ext     = adr_nx[AW-1:AW-2];
  wire          adr_end = (phase == ADR) && (cnt == CW'(AW - 1));
  wire          dat_end = (phase == DAT) && (cnt == CW'(DW - 1));

  assign sdo = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      wen   <= 1'b0;
      sdo_q <= 1'b0;
      op    <= '0;
      adr   <= '0;
      dat   <= '0;
      rsh   <= '0;
      cnt   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (!sel) begin
      phase <= IDLE;
      sdo_q <= 1'b0;
      cnt   <= '0;
    end else if (rise) begin
      case (phase)
        IDLE: if (sdi) begin
          phase <= OPC;
          cnt   <= '0;
        end
        OPC: begin
          op  <= {op[0], sdi};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1)) begin
            phase <= ADR;
            cnt   <= '0;
          end
        end
        ADR: begin
          adr <= adr_nx;
          cnt <= cnt + 1'b1;
          if (adr_end) begin
            cnt   <= '0;
            phase <= FIN;
            case (op)
              2'b10: begin
                phase <= RDO;
                rsh   <= mem[adr_nx];
                sdo_q <= 1'b0;
              end
              2'b01: phase <= DAT;
              2'b11: if (wen) mem[adr_nx] <= '1;
              default: case (ext)
                2'b11: wen <= 1'b1;
                2'b00: wen <= 1'b0;
                2'b10: if (wen) for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                default: phase <= DAT;
              endcase
            endcase
          end
        end
        DAT: begin
          dat <= dat_nx;
          cnt <= cnt + 1'b1;
          if (dat_end) begin
            phase <= FIN;
            if (wen) begin
              if (op == 2'b01) mem[adr] <= dat_nx;
              else for (int i = 0; i < DEPTH; i++) mem[i] <= dat_nx;
            end
          end
        end
        RDO: begin
          if (cnt == CW'(DW)) begin
            sdo_q <= 1'b0;
            phase <= FIN;
          end else begin
            sdo_q <= rsh[DW-1];
            rsh   <= {rsh[DW-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (phase == IDLE) && !sdo);

  a_r11_sdo_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo) |-> $past(phase) == RDO);

  a_r6_wen_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(wen));

  a_r12_addr_count: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ADR) |-> cnt < CW'(AW));

  a_r3_read_count: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == RDO) |-> cnt <= CW'(DW));
endmodule

// File: tb/tb_sereep_model.sv
module tb_sereep_model;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] expv [N];

  sereep_model #(.AW(AW)) dut (.clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi), .sdo(sdo));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    sdi = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic endc();
    sclk = 1'b0; sel = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [AW-1:0] a);
    sel = 1'b1;
    sbit(1'b1); sbit(op[1]); sbit(op[0]);
    for (int i = AW - 1; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic sdata(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) sbit(d[i]);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    hdr(2'b10, a);
    chk("R3 dummy zero", {15'd0, sdo}, 16'd0);
    v = '0;
    for (int i = 0; i < 16; i++) begin
      sbit(1'b0);
      v = {v[14:0], sdo};
    end
    sbit(1'b0);
    chk("R3 zero after bit0", {15'd0, sdo}, 16'd0);
    endc();
  endtask

  task automatic rd_all(input string req);
    logic [15:0] v;
    for (int a = 0; a < N; a++) begin
      rd(AW'(a), v);
      chk(req, v, expv[a]);
    end
  endtask

  task automatic ext(input logic [1:0] top, input logic [3:0] low, input logic [15:0] d);
    hdr(2'b00, {top, low});
    if (top == 2'b01) sdata(d);
    endc();
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0397) ^ 16'hA5C3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int a = 0; a < N; a++) expv[a] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sdo after reset", {15'd0, sdo}, 16'd0);
    rd(0, v);      chk("R1 erased word 0", v, 16'hFFFF);
    rd(N - 1, v);  chk("R1 erased top word", v, 16'hFFFF);

    // R9 / R1: writes disabled after reset
    hdr(2'b01, 6'd5); sdata(16'h1234); endc();
    rd(5, v); chk("R9 write refused after reset", v, 16'hFFFF);

    // R6: enable with odd low bits; R4/R12 sweep
    ext(2'b11, 4'b0101, 16'h0);
    for (int a = 0; a < N; a++) begin
      hdr(2'b01, AW'(a)); sdata(pat(a)); endc();
      expv[a] = pat(a);
    end
    rd_all("R4 R12 write sweep");

    // R5: erase one word
    hdr(2'b11, 6'd10); endc(); expv[10] = 16'hFFFF;
    rd(10, v); chk("R5 erased word", v, 16'hFFFF);
    rd(11, v); chk("R5 neighbour kept", v, expv[11]);
    rd(9, v);  chk("R5 neighbour kept", v, expv[9]);

    // R10: abort write in data phase; R11: sdo low while sel low
    hdr(2'b01, 6'd3);
    for (int i = 0; i < 10; i++) sbit(1'b0);
    endc();
    chk("R11 sdo low with sel low", {15'd0, sdo}, 16'd0);
    rd(3, v); chk("R10 aborted write", v, expv[3]);
    // R10: abort read mid-word, then a fresh read works
    hdr(2'b10, 6'd20); sbit(1'b0); sbit(1'b0); endc();
    chk("R11 sdo low after abort", {15'd0, sdo}, 16'd0);
    rd(20, v); chk("R10 read after abort", v, expv[20]);

    // R2: leading zeros before start bit
    sel = 1'b1; sbit(1'b0); sbit(1'b0); sbit(1'b0);
    rd(33, v); chk("R2 leading zeros skipped", v, expv[33]);

    // R6 disable with odd low bits, R9 everything refused
    ext(2'b00, 4'b1010, 16'h0);
    hdr(2'b01, 6'd7); sdata(16'h0000); endc();
    rd(7, v); chk("R9 write refused after disable", v, expv[7]);
    hdr(2'b11, 6'd8); endc();
    rd(8, v); chk("R9 erase refused", v, expv[8]);
    ext(2'b10, 4'b0110, 16'h0);
    rd(12, v); chk("R9 erase-all refused", v, expv[12]);
    ext(2'b01, 4'b1001, 16'h5A5A);
    rd_all("R9 write-all refused");

    // R8 then R7
    ext(2'b11, 4'b1111, 16'h0);
    ext(2'b01, 4'b0011, 16'h1234);
    for (int a = 0; a < N; a++) expv[a] = 16'h1234;
    rd_all("R8 write-all");
    ext(2'b10, 4'b0001, 16'h0);
    for (int a = 0; a < N; a++) expv[a] = 16'hFFFF;
    rd_all("R7 erase-all");

    // R1: reset clears the enable latch
    hdr(2'b01, 6'd2); sdata(16'h00F0); endc();
    rd(2, v); chk("R4 write while enabled", v, 16'h00F0);
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (2) @(negedge clk);
    hdr(2'b01, 6'd2); sdata(16'h0F0F); endc();
    rd(2, v); chk("R1 latch clear after reset", v, 16'hFFFF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule